// File: doc/BRIEF.md
# Six-Bit Divide-by-Ten Unit

This unit splits a small unsigned value into a tens digit and a units digit in one combinational pass. It takes a 6-bit dividend and returns the quotient and remainder of division by ten. It also reports which band of ten values the dividend lies in. A digit generator can use it at the step where each new digit is peeled off an intermediate sum.

The unit does not iterate. It compares the dividend against the fixed band floors 10, 20, 30, 40, 50 and 60. This gives a one-hot band indicator, and the binary quotient is encoded from that indicator. The same indicator selects the matching multiple of ten. That multiple is subtracted from the dividend by adding its bitwise complement with a carry-in of one. Every multiple of ten is even, so the lowest dividend bit goes straight to the remainder and only the upper bits pass through the adder.

Top module: `dten_divider`

## Requirements
- R1: For a dividend `a` in 0..63, `quot_o` is 0 for 0..9, 1 for 10..19, 2 for 20..29, 3 for 30..39, 4 for 40..49, 5 for 50..59 and 6 for 60..63.
- R2: `rem_o` equals `a` minus ten times `quot_o`, so it always lies in 0..9, and `quot_o*10 + rem_o == a`.
- R3: `decade_o` is 7 bits wide. Bit k is 1 exactly when `a` lies in 10k..10k+9, and bit 6 covers 60..63. Exactly one bit is set for every dividend.
- R4: `quot_o` is the binary index of the set bit of `decade_o`, and it never takes the value 7.
- R5: Bit 0 of `rem_o` always equals bit 0 of the dividend.
- R6: Dividend 0x3A gives quotient 5 and remainder 8. 0x31 gives 4 and 9, 0x3F gives 6 and 3, and 0x1E gives 3 and 0.
- R7: At the band edges, 0 gives 0 and 0, 9 gives 0 and 9, 10 gives 1 and 0, 59 gives 5 and 9, 60 gives 6 and 0, and 63 gives 6 and 3.
- R8: The unit holds no state. Its outputs follow a change of the dividend without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend_i | input | 6 | Unsigned value to be divided by ten |
| quot_o | output | 3 | Binary quotient, 0..6 |
| rem_o | output | 4 | Remainder, 0..9 |
| decade_o | output | 7 | One-hot marker of the band of ten holding the dividend |

## Verification
The bench builds the unit with its default parameters, a 6-bit dividend and a divisor of ten. With those values the whole input space is only 64 entries, so an exhaustive sweep covers every band, every band edge and every remainder digit. The sweep is compared against integer division and modulo computed in the bench. A final mid-cycle input change, with no clock edge in between, shows that the outputs follow the dividend directly.

// File: rtl/dten_pkg.sv
package dten_pkg;

    // Number of bands of DIVISOR values that a W-bit unsigned value spans.
    function automatic int unsigned band_count(int unsigned w, int unsigned d);
        return (((1 << w) - 1) / d) + 1;
    endfunction

    // Bits needed to hold the values 0 .. n-1.
    function automatic int unsigned index_bits(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dten_band_decoder.sv
module dten_band_decoder #(
    parameter int unsigned DIV_W   = 6,
    parameter int unsigned DIVISOR = 10,
    parameter int unsigned NBAND   = 7
) (
    input  logic [DIV_W-1:0] value_i,
    output logic [NBAND-1:0] band_o
);

    // floor_hit[k] is set when the value reaches the floor of band k.
    logic [NBAND:0] floor_hit;

    assign floor_hit[NBAND] = 1'b0;

    for (genvar k = 0; k < NBAND; k++) begin : g_floor
        if (k == 0) begin : g_base
            assign floor_hit[k] = 1'b1;
        end else begin : g_cmp
            localparam int unsigned FLOOR_V = k * DIVISOR;
            assign floor_hit[k] = (value_i >= DIV_W'(FLOOR_V));
        end
    end

    for (genvar k = 0; k < NBAND; k++) begin : g_band
        assign band_o[k] = floor_hit[k] & ~floor_hit[k+1];
    end

    always_comb begin
        AST_ONE_BAND: assert ($countones(band_o) == 1) else $error("band marker not one-hot"); // R3
    end

endmodule

// File: rtl/dten_index_encoder.sv
module dten_index_encoder #(
    parameter int unsigned NBAND = 7,
    parameter int unsigned IDX_W = 3
) (
    input  logic [NBAND-1:0] hot_i,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NBAND; k++) begin
            if (hot_i[k]) begin
                idx_o = idx_o | IDX_W'(k);
            end
        end
    end

    always_comb begin
        AST_INDEX_BOUND: assert (int'(idx_o) < int'(NBAND)) else $error("quotient index out of range"); // R4
    end

endmodule

// File: rtl/dten_multiple_select.sv
module dten_multiple_select #(
    parameter int unsigned DIV_W   = 6,
    parameter int unsigned DIVISOR = 10,
    parameter int unsigned NBAND   = 7
) (
    input  logic [NBAND-1:0] hot_i,
    output logic [DIV_W-1:0] mult_o
);

    // OR of the band floors gated by the one-hot marker.
    always_comb begin
        mult_o = '0;
        for (int k = 0; k < NBAND; k++) begin
            if (hot_i[k]) begin
                mult_o = mult_o | DIV_W'(k * DIVISOR);
            end
        end
    end

endmodule

// File: rtl/dten_rem_adder.sv
module dten_rem_adder #(
    parameter int unsigned DIV_W   = 6,
    parameter int unsigned DIVISOR = 10,
    parameter int unsigned REM_W   = 4
) (
    input  logic [DIV_W-1:0] value_i,
    input  logic [DIV_W-1:0] mult_i,
    output logic [REM_W-1:0] rem_o
);

    logic [DIV_W-1:0] diff;

    if (DIVISOR % 2 == 0) begin : g_even
        // Every multiple is even, so bit 0 bypasses the adder.
        localparam logic [DIV_W-2:0] ONE_U = 1;
        logic [DIV_W-2:0] upper_sum;
        assign upper_sum = value_i[DIV_W-1:1] + ~mult_i[DIV_W-1:1] + ONE_U;
        assign diff      = {upper_sum, value_i[0]};

        always_comb begin
            AST_MULT_EVEN: assert (mult_i[0] == 1'b0) else $error("odd multiple selected"); // R5
        end
    end else begin : g_odd
        localparam logic [DIV_W-1:0] ONE_F = 1;
        assign diff = value_i + ~mult_i + ONE_F;
    end

    assign rem_o = diff[REM_W-1:0];

    always_comb begin
        AST_DIFF_FITS: assert (diff[DIV_W-1:REM_W] == '0) else $error("difference wider than remainder"); // R2
    end

endmodule

// File: rtl/dten_divider.sv
module dten_divider #(
    parameter int unsigned DIV_W   = 6,
    parameter int unsigned DIVISOR = 10,
    localparam int unsigned NBAND  = dten_pkg::band_count(DIV_W, DIVISOR),
    localparam int unsigned QUOT_W = dten_pkg::index_bits(NBAND),
    localparam int unsigned REM_W  = dten_pkg::index_bits(DIVISOR)
) (
    input  logic [DIV_W-1:0]  dividend_i,
    output logic [QUOT_W-1:0] quot_o,
    output logic [REM_W-1:0]  rem_o,
    output logic [NBAND-1:0]  decade_o
);

    logic [NBAND-1:0] band;
    logic [DIV_W-1:0] multiple;

    dten_band_decoder #(
        .DIV_W  (DIV_W),
        .DIVISOR(DIVISOR),
        .NBAND  (NBAND)
    ) u_band (
        .value_i(dividend_i),
        .band_o (band)
    );

    dten_index_encoder #(
        .NBAND(NBAND),
        .IDX_W(QUOT_W)
    ) u_index (
        .hot_i(band),
        .idx_o(quot_o)
    );

    dten_multiple_select #(
        .DIV_W  (DIV_W),
        .DIVISOR(DIVISOR),
        .NBAND  (NBAND)
    ) u_mult (
        .hot_i (band),
        .mult_o(multiple)
    );

    dten_rem_adder #(
        .DIV_W  (DIV_W),
        .DIVISOR(DIVISOR),
        .REM_W  (REM_W)
    ) u_rem (
        .value_i(dividend_i),
        .mult_i (multiple),
        .rem_o  (rem_o)
    );

    assign decade_o = band;

    always_comb begin
        AST_REBUILD: assert (int'(quot_o) * int'(DIVISOR) + int'(rem_o) == int'(dividend_i)) else $error("quotient and remainder do not rebuild dividend"); // R2
        AST_REM_BELOW: assert (int'(rem_o) < int'(DIVISOR)) else $error("remainder not below divisor"); // R2
        AST_QUOT_MATCH_BAND: assert (band[quot_o] == 1'b1) else $error("quotient disagrees with band marker"); // R4
    end

    if (DIVISOR % 2 == 0) begin : g_lsb_chk
        always_comb begin
            AST_LSB_KEPT: assert (rem_o[0] == dividend_i[0]) else $error("remainder lsb differs from dividend lsb"); // R5
        end
    end

endmodule

// File: tb/dten_divider_test.sv
module dten_divider_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic [5:0] dividend;
    logic [2:0] quot;
    logic [3:0] rem;
    logic [6:0] decade;

    dten_divider uut (
        .dividend_i(dividend),
        .quot_o    (quot),
        .rem_o     (rem),
        .decade_o  (decade)
    );

    typedef struct {
        logic [5:0] a;
        logic [2:0] q;
        logic [3:0] r;
        logic [6:0] dec;
        string      tag;
    } item_t;

    item_t expq[$];
    int    total    = 0;
    int    bad      = 0;
    bit    finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] a, input string tag);
        item_t it;
        @(negedge clk);
        dividend = a;
        it.a   = a;
        it.q   = 3'(int'(a) / 10);
        it.r   = 4'(int'(a) % 10);
        it.dec = 7'(1) << (int'(a) / 10);
        it.tag = tag;
        expq.push_back(it);
    endtask

    // Monitor: pops one expected item per cycle and compares.
    initial begin
        item_t it;
        int    pos;
        wait (rst_n);
        forever begin
            @(posedge clk);
            #2;
            if (expq.size() > 0) begin
                it = expq.pop_front();
                check(quot == it.q, "R1", $sformatf("%s quotient a=%0d", it.tag, it.a), int'(quot), int'(it.q));
                check(rem == it.r, "R2", $sformatf("%s remainder a=%0d", it.tag, it.a), int'(rem), int'(it.r));
                check(decade == it.dec, "R3", $sformatf("%s band marker a=%0d", it.tag, it.a), int'(decade), int'(it.dec));
                check($countones(decade) == 1, "R3", $sformatf("%s one-hot a=%0d", it.tag, it.a), $countones(decade), 1);
                pos = -1;
                for (int k = 0; k < 7; k++) if (decade[k]) pos = k;
                check(pos == int'(quot) && quot != 3'd7, "R4", $sformatf("%s index of band a=%0d", it.tag, it.a), int'(quot), pos);
                check(rem[0] == it.a[0], "R5", $sformatf("%s lsb a=%0d", it.tag, it.a), int'(rem[0]), int'(it.a[0]));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=expired expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        dividend = 6'd0;
        #3;
        // Reset state: dividend held at zero
        check(quot == 3'd0, "R1", "reset quotient", int'(quot), 0);
        check(rem == 4'd0, "R2", "reset remainder", int'(rem), 0);
        check(decade == 7'b0000001, "R3", "reset band marker", int'(decade), 1);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R6 worked cases
        drive(6'h3A, "R6");
        drive(6'h31, "R6");
        drive(6'h3F, "R6");
        drive(6'h1E, "R6");

        // R7 band edges
        drive(6'd0,  "R7");
        drive(6'd9,  "R7");
        drive(6'd10, "R7");
        drive(6'd59, "R7");
        drive(6'd60, "R7");
        drive(6'd63, "R7");
        drive(6'd19, "R7");
        drive(6'd20, "R7");

        // Full sweep, ascending then descending
        for (int v = 0; v < 64; v++) drive(6'(v), "sweep-up");
        for (int v = 63; v >= 0; v--) drive(6'(v), "sweep-down");

        while (expq.size() != 0) @(posedge clk);
        @(posedge clk);
        #3;
        // R8: change the input mid-cycle, no clock edge before sampling
        dividend = 6'd45;
        #1;
        check(quot == 3'd4, "R8", "no-clock quotient", int'(quot), 4);
        check(rem == 4'd5, "R8", "no-clock remainder", int'(rem), 5);
        dividend = 6'd7;
        #1;
        check(quot == 3'd0 && rem == 4'd7, "R8", "no-clock follow-up", int'({quot, rem}), int'({3'd0, 4'd7}));

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule